// File: doc/BRIEF.md
# Ordered-Retirement Store Queue

This block holds the stores of an out-of-order core between dispatch and the point where the data cache has accepted and finished them. Stores enter at the tail in program order. Each entry carries a sequence number, an access size, an address and data. The commit stage gives the youngest committed sequence number. The queue then marks the covered entries, counting from the oldest, as allowed to write back. A separate writeback pointer sends these entries to a multi-lane cache write interface, oldest first.

The cache may finish stores in any order. The oldest-entry (head) pointer frees slots only across an unbroken run of finished entries. A squash removes young stores that are not yet eligible, counting back from the tail, and stops at the first entry that may already be writing back. One load can be parked on a chosen store. It gets a replay pulse when that store is handed to the cache or when the store finishes.

The queue always keeps one slot unused, so that a full queue and an empty queue look different. The depth must be a power of two.

Top module: `store_queue`

## Requirements
- R1: After reset, the queue is empty. `free_cnt` equals DEPTH-1, no write lane is valid and `replay_go` is 0.
- R2: `free_cnt` equals DEPTH-1 minus the number of occupied entries. An allocation when `free_cnt` is 0 is refused, and `alloc_err` is 1 in the following cycle.
- R3: The legal values of `alloc_size` are 0, 1, 2, 4 and 8. Any other value is refused with `alloc_err` in the following cycle, and the queue stays unchanged.
- R4: A commit marks entries eligible, walking from the head. It passes over entries that are already eligible and marks each entry whose sequence number is at or below `commit_seq`. It stops at the first younger entry that is not eligible. Entries that are not eligible never appear on a write lane.
- R5: Eligible entries are presented from the writeback pointer in queue order, with the pointer wrapping modulo DEPTH. Lane 0 carries the oldest entry. At most PORTS entries are presented per cycle, and the valid lanes always form a run that starts at lane 0.
- R6: While `wr_ready` is 0, no entry with a non-zero size advances, and the presented lanes keep the same entries.
- R7: An eligible entry of size 0 takes no lane. It is marked finished when the writeback pointer reaches it, even while `wr_ready` is 0, provided it comes before any entry with a non-zero size in that cycle's window.
- R8: A `cpl_valid` pulse marks the entry `cpl_idx` finished. Completions may arrive in any order. The head advances across the whole contiguous finished run one cycle after the finishing event, and never past an entry that is not finished.
- R9: A squash removes, from the tail backward, entries that are not eligible and whose sequence number is greater than `squash_seq`. It stops at the first eligible entry. An allocation or a commit in the same cycle as a squash is ignored.
- R10: After `stall_set` with `stall_idx`, `replay_go` pulses for one cycle after the cycle in which that store is accepted on a lane or finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new store |
| alloc_size | input | 4 | Access size in bytes (0,1,2,4,8) |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_err | output | 1 | Previous allocation was refused (illegal size or full) |
| free_cnt | output | IDX_W | Free entries, one spare slot excluded |
| empty | output | 1 | No entries held |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| wr_valid | output | PORTS | Per-lane request valid |
| wr_addr | output | PORTS*ADDR_W | Per-lane address |
| wr_size | output | PORTS*4 | Per-lane size |
| wr_data | output | PORTS*DATA_W | Per-lane data |
| wr_idx | output | PORTS*IDX_W | Per-lane queue index |
| wr_ready | input | 1 | Cache accepts all valid lanes; low means blocked |
| cpl_valid | input | 1 | Completion pulse |
| cpl_idx | input | IDX_W | Index of the finished store |
| stall_set | input | 1 | Park a load on a store |
| stall_idx | input | IDX_W | Store index the load waits for |
| replay_go | output | 1 | Parked load may replay |

## Verification
The hardest state to reach is a head that is held back by one unfinished entry while younger entries have already finished. Another is a squash that meets an eligible entry part-way back from the tail. The stimulus holds `wr_ready` low so that eligible entries stay in place. It finishes stores out of order, and it issues a squash together with a commit and an allocation, so that ignoring both of them can be seen on the lanes and in `free_cnt`. A last sequence fills across the index wrap and finishes the stores in reverse order.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SZ_W = 4;

  function automatic logic size_ok(input logic [SZ_W-1:0] s);
    return (s == 4'd0) || (s == 4'd1) || (s == 4'd2) || (s == 4'd4) || (s == 4'd8);
  endfunction
endpackage

// File: rtl/sq_payload.sv
module sq_payload #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int PORTS = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] raddr [PORTS],
  output logic [W-1:0]     rdata [PORTS]
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/sq_run_len.sv
module sq_run_len #(
  parameter int DEPTH    = 8,
  parameter bit BACKWARD = 1'b0,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] start,
  input  logic [IDX_W-1:0] limit,
  input  logic [DEPTH-1:0] pred,
  output logic [IDX_W-1:0] len,
  output logic [DEPTH-1:0] in_run
);
  logic [IDX_W-1:0] idx;
  logic             go;

  always_comb begin
    len    = '0;
    in_run = '0;
    go     = 1'b1;
    idx    = start;
    for (int k = 0; k < DEPTH; k++) begin
      idx = BACKWARD ? start - IDX_W'(k) : start + IDX_W'(k);
      if (go && (k < int'(limit)) && pred[idx]) begin
        len         = len + 1'b1;
        in_run[idx] = 1'b1;
      end else begin
        go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/sq_wb_pick.sv
module sq_wb_pick #(
  parameter int DEPTH = 8,
  parameter int PORTS = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] wb_ptr,
  input  logic [IDX_W-1:0] limit,
  input  logic [DEPTH-1:0] elig,
  input  logic [DEPTH-1:0] zero,
  input  logic             ready,
  output logic [PORTS-1:0] lane_v,
  output logic [IDX_W-1:0] lane_idx [PORTS],
  output logic [IDX_W-1:0] adv,
  output logic [DEPTH-1:0] zc
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] adv_all, adv_pre;
  logic [DEPTH-1:0] zc_all, zc_pre;
  logic             go, pre;
  int               lane;

  always_comb begin
    lane_v  = '0;
    for (int p = 0; p < PORTS; p++) lane_idx[p] = '0;
    adv_all = '0;
    adv_pre = '0;
    zc_all  = '0;
    zc_pre  = '0;
    go      = 1'b1;
    pre     = 1'b1;
    lane    = 0;
    idx     = wb_ptr;
    for (int j = 0; j < PORTS; j++) begin
      idx = wb_ptr + IDX_W'(j);
      if (go && (j < int'(limit)) && elig[idx]) begin
        adv_all = adv_all + 1'b1;
        if (zero[idx]) begin
          zc_all[idx] = 1'b1;
          if (pre) begin
            zc_pre[idx] = 1'b1;
            adv_pre     = adv_pre + 1'b1;
          end
        end else begin
          pre = 1'b0;
          if (lane < PORTS) begin
            lane_v[lane]   = 1'b1;
            lane_idx[lane] = idx;
          end
          lane = lane + 1;
        end
      end else begin
        go = 1'b0;
      end
    end
    adv = ready ? adv_all : adv_pre;
    zc  = ready ? zc_all  : zc_pre;
  end
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PORTS  = 2,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PAY_W = ADDR_W + SZ_W + DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  input  logic [SEQ_W-1:0]         alloc_seq,
  input  logic [SZ_W-1:0]          alloc_size,
  input  logic [ADDR_W-1:0]        alloc_addr,
  input  logic [DATA_W-1:0]        alloc_data,
  output logic                     alloc_err,
  output logic [IDX_W-1:0]         free_cnt,
  output logic                     empty,
  input  logic                     commit_valid,
  input  logic [SEQ_W-1:0]         commit_seq,
  input  logic                     squash_valid,
  input  logic [SEQ_W-1:0]         squash_seq,
  output logic [PORTS-1:0]         wr_valid,
  output logic [PORTS*ADDR_W-1:0]  wr_addr,
  output logic [PORTS*SZ_W-1:0]    wr_size,
  output logic [PORTS*DATA_W-1:0]  wr_data,
  output logic [PORTS*IDX_W-1:0]   wr_idx,
  input  logic                     wr_ready,
  input  logic                     cpl_valid,
  input  logic [IDX_W-1:0]         cpl_idx,
  input  logic                     stall_set,
  input  logic [IDX_W-1:0]         stall_idx,
  output logic                     replay_go
);
  // pointers and per-entry flags
  logic [IDX_W-1:0] head_q, tail_q, wb_q;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] elig_q, done_q, zero_q;
  logic [DEPTH-1:0] elig_nx, done_nx, zero_nx;
  logic             stalled_q, err_q, replay_q;
  logic [IDX_W-1:0] stall_ix_q;

  logic [IDX_W-1:0] occ, wb_span;
  logic             accept, refuse;

  assign occ      = tail_q - head_q;
  assign wb_span  = tail_q - wb_q;
  assign free_cnt = IDX_W'(DEPTH - 1) - occ;
  assign empty    = (head_q == tail_q);
  assign accept   = alloc_valid && !squash_valid && size_ok(alloc_size) && (free_cnt != '0);
  assign refuse   = alloc_valid && !squash_valid && (!size_ok(alloc_size) || (free_cnt == '0));

  // per-entry predicates for the three walks
  logic [DEPTH-1:0] cmt_pred, sqh_pred;
  for (genvar i = 0; i < DEPTH; i++) begin : g_pred
    assign cmt_pred[i] = elig_q[i] | (seq_q[i] <= commit_seq);
    assign sqh_pred[i] = ~elig_q[i] & (seq_q[i] > squash_seq);
  end

  logic [IDX_W-1:0] cmt_len, sqh_len, ret_len;
  logic [DEPTH-1:0] cmt_run, sqh_run, ret_run;

  sq_run_len #(.DEPTH(DEPTH), .BACKWARD(1'b0)) u_commit (
    .start(head_q), .limit(occ), .pred(cmt_pred), .len(cmt_len), .in_run(cmt_run)
  );

  sq_run_len #(.DEPTH(DEPTH), .BACKWARD(1'b1)) u_squash (
    .start(tail_q - 1'b1), .limit(occ), .pred(sqh_pred), .len(sqh_len), .in_run(sqh_run)
  );

  sq_run_len #(.DEPTH(DEPTH), .BACKWARD(1'b0)) u_retire (
    .start(head_q), .limit(occ), .pred(done_q), .len(ret_len), .in_run(ret_run)
  );

  // writeback selection
  logic [PORTS-1:0] lane_v;
  logic [IDX_W-1:0] lane_idx [PORTS];
  logic [IDX_W-1:0] wb_adv;
  logic [DEPTH-1:0] zc_mask;

  sq_wb_pick #(.DEPTH(DEPTH), .PORTS(PORTS)) u_pick (
    .wb_ptr(wb_q), .limit(wb_span), .elig(elig_q), .zero(zero_q), .ready(wr_ready),
    .lane_v(lane_v), .lane_idx(lane_idx), .adv(wb_adv), .zc(zc_mask)
  );

  // payload storage
  logic [PAY_W-1:0] rd_word [PORTS];

  sq_payload #(.DEPTH(DEPTH), .W(PAY_W), .PORTS(PORTS)) u_pay (
    .clk(clk), .we(accept), .waddr(tail_q),
    .wdata({alloc_addr, alloc_size, alloc_data}),
    .raddr(lane_idx), .rdata(rd_word)
  );

  for (genvar l = 0; l < PORTS; l++) begin : g_lane
    assign wr_valid[l]                   = lane_v[l];
    assign wr_idx[l*IDX_W +: IDX_W]      = lane_idx[l];
    assign wr_addr[l*ADDR_W +: ADDR_W]   = rd_word[l][PAY_W-1 -: ADDR_W];
    assign wr_size[l*SZ_W +: SZ_W]       = rd_word[l][DATA_W +: SZ_W];
    assign wr_data[l*DATA_W +: DATA_W]   = rd_word[l][DATA_W-1:0];
  end

  // flag next-state
  always_comb begin
    elig_nx = elig_q;
    done_nx = done_q | zc_mask;
    zero_nx = zero_q;
    if (commit_valid && !squash_valid) elig_nx = elig_q | cmt_run;
    if (cpl_valid) done_nx[cpl_idx] = 1'b1;
    if (accept) begin
      elig_nx[tail_q] = 1'b0;
      done_nx[tail_q] = 1'b0;
      zero_nx[tail_q] = (alloc_size == '0);
    end
  end

  // parked-load release
  logic hit_issue, release_now;
  always_comb begin
    hit_issue = 1'b0;
    for (int p = 0; p < PORTS; p++)
      if (lane_v[p] && (lane_idx[p] == stall_ix_q)) hit_issue = 1'b1;
    release_now = stalled_q && ((wr_ready && hit_issue) ||
                                (cpl_valid && (cpl_idx == stall_ix_q)) ||
                                zc_mask[stall_ix_q]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q     <= '0;
      tail_q     <= '0;
      wb_q       <= '0;
      elig_q     <= '0;
      done_q     <= '0;
      zero_q     <= '0;
      stalled_q  <= 1'b0;
      stall_ix_q <= '0;
      err_q      <= 1'b0;
      replay_q   <= 1'b0;
    end else begin
      head_q <= head_q + ret_len;
      wb_q   <= wb_q + wb_adv;
      if (squash_valid)  tail_q <= tail_q - sqh_len;
      else if (accept)   tail_q <= tail_q + 1'b1;
      elig_q   <= elig_nx;
      done_q   <= done_nx;
      zero_q   <= zero_nx;
      err_q    <= refuse;
      replay_q <= release_now;
      if (stall_set) begin
        stalled_q  <= 1'b1;
        stall_ix_q <= stall_idx;
      end else if (release_now) begin
        stalled_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) seq_q[tail_q] <= alloc_seq;
  end

  assign alloc_err = err_q;
  assign replay_go = replay_q;
endmodule

// File: rtl/sq_checker.sv
module sq_checker
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PORTS = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   alloc_valid,
  input logic [SZ_W-1:0]        alloc_size,
  input logic                   alloc_err,
  input logic [IDX_W-1:0]       free_cnt,
  input logic                   empty,
  input logic                   squash_valid,
  input logic [PORTS-1:0]       wr_valid,
  input logic [PORTS*IDX_W-1:0] wr_idx,
  input logic                   wr_ready,
  input logic                   replay_go,
  input logic                   stalled_q
);
  logic [PORTS-1:0] v_inc;
  assign v_inc = wr_valid + 1'b1;

  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    empty |-> (wr_valid == '0));

  a_r5_lanes_packed: assert property (@(posedge clk) disable iff (rst)
    (v_inc & wr_valid) == '0);

  a_r6_blocked_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid[0] && !wr_ready) |=> (wr_valid[0] && $stable(wr_idx[IDX_W-1:0])));

  a_r3_bad_size_err: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !squash_valid && !size_ok(alloc_size)) |=> alloc_err);

  a_r9_squash_frees: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> (free_cnt >= $past(free_cnt)));

  a_r10_replay_cause: assert property (@(posedge clk) disable iff (rst)
    replay_go |-> $past(stalled_q));
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .PORTS(PORTS)) u_sq_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_size(alloc_size),
  .alloc_err(alloc_err), .free_cnt(free_cnt), .empty(empty),
  .squash_valid(squash_valid), .wr_valid(wr_valid), .wr_idx(wr_idx),
  .wr_ready(wr_ready), .replay_go(replay_go), .stalled_q(stalled_q)
);

// File: tb/store_queue_tb_top.sv
module store_queue_tb_top;
  localparam int DEPTH = 8, PORTS = 2, SEQ_W = 16, ADDR_W = 16, DATA_W = 32;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic alloc_valid = 0, commit_valid = 0, squash_valid = 0, wr_ready = 0;
  logic cpl_valid = 0, stall_set = 0;
  logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [3:0] alloc_size = '0;
  logic [ADDR_W-1:0] alloc_addr = '0;
  logic [DATA_W-1:0] alloc_data = '0;
  logic [IDX_W-1:0] cpl_idx = '0, stall_idx = '0;
  logic alloc_err, empty, replay_go;
  logic [IDX_W-1:0] free_cnt;
  logic [PORTS-1:0] wr_valid;
  logic [PORTS*ADDR_W-1:0] wr_addr;
  logic [PORTS*4-1:0] wr_size;
  logic [PORTS*DATA_W-1:0] wr_data;
  logic [PORTS*IDX_W-1:0] wr_idx;

  store_queue #(.DEPTH(DEPTH), .PORTS(PORTS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_size(alloc_size), .alloc_addr(alloc_addr), .alloc_data(alloc_data),
    .alloc_err(alloc_err), .free_cnt(free_cnt), .empty(empty),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .wr_idx(wr_idx), .wr_ready(wr_ready), .cpl_valid(cpl_valid), .cpl_idx(cpl_idx),
    .stall_set(stall_set), .stall_idx(stall_idx), .replay_go(replay_go)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input int seq, input int size, input int addr, input int data);
    alloc_valid = 1; alloc_seq = SEQ_W'(seq); alloc_size = 4'(size);
    alloc_addr = ADDR_W'(addr); alloc_data = DATA_W'(data);
    tick();
    alloc_valid = 0;
  endtask

  task automatic commit(input int seq);
    commit_valid = 1; commit_seq = SEQ_W'(seq); tick(); commit_valid = 0;
  endtask

  task automatic complete(input int idx);
    cpl_valid = 1; cpl_idx = IDX_W'(idx); tick(); cpl_valid = 0;
  endtask

  function automatic int lidx(input int l);
    return int'(wr_idx[l*IDX_W +: IDX_W]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1 empty", empty, 1);
    check("R1 free", free_cnt, DEPTH - 1);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 replay", replay_go, 0);

    // R3 illegal sizes refused
    put(99, 3, 'h10, 0);
    check("R3 err size3", alloc_err, 1);
    check("R3 free size3", free_cnt, DEPTH - 1);
    put(99, 5, 'h10, 0);
    check("R3 err size5", alloc_err, 1);
    check("R3 empty kept", empty, 1);

    // R2 fill: idx0..6 seq 10..16, sizes 8,4,0,2,1,8,4
    for (int i = 0; i < DEPTH - 1; i++) begin
      int sz;
      case (i) 0: sz = 8; 1: sz = 4; 2: sz = 0; 3: sz = 2; 4: sz = 1; 5: sz = 8; default: sz = 4; endcase
      put(10 + i, sz, 'h100 + i, 'hA000 + i);
      check("R2 free during fill", free_cnt, DEPTH - 2 - i);
      check("R3 legal no err", alloc_err, 0);
      check("R4 uncommitted idle", wr_valid, 0);
    end
    put(50, 1, 0, 0);
    check("R2 full refused err", alloc_err, 1);
    check("R2 full free", free_cnt, 0);

    // R4 commit up to seq 12 with cache blocked; park a load on idx1
    stall_set = 1; stall_idx = 1;
    commit(12);
    stall_set = 0;
    check("R4 lanes after commit", wr_valid, 3);
    check("R5 lane0 idx", lidx(0), 0);
    check("R5 lane1 idx", lidx(1), 1);
    check("R5 lane0 addr", wr_addr[ADDR_W-1:0], 'h100);
    check("R5 lane1 size", wr_size[7:4], 4);
    tick();
    check("R6 hold valid", wr_valid, 3);
    check("R6 hold idx0", lidx(0), 0);
    check("R6 hold idx1", lidx(1), 1);
    check("R10 no early replay", replay_go, 0);

    // R5/R10 accept both lanes
    wr_ready = 1;
    tick();
    wr_ready = 0;
    check("R10 replay on issue", replay_go, 1);
    check("R7 zero entry no lane", wr_valid, 0);
    tick();
    check("R7 still no lane", wr_valid, 0);
    check("R10 replay one pulse", replay_go, 0);

    // R8 out of order completion
    complete(1);
    check("R8 head held", free_cnt, 0);
    tick();
    check("R8 head still held", free_cnt, 0);
    complete(0);
    check("R8 retire latency", free_cnt, 0);
    tick();
    check("R8 run retired", free_cnt, 3);

    // R9 squash stops at eligible entry, ignores same-cycle commit and alloc
    commit(13);
    check("R4 idx3 eligible", wr_valid, 1);
    check("R4 lane0 idx3", lidx(0), 3);
    squash_valid = 1; squash_seq = 14; commit_valid = 1; commit_seq = 15;
    alloc_valid = 1; alloc_seq = 40; alloc_size = 1;
    tick();
    squash_valid = 0; commit_valid = 0; alloc_valid = 0;
    check("R9 free after squash", free_cnt, 5);
    check("R9 commit ignored", wr_valid, 1);
    check("R9 alloc no err", alloc_err, 0);
    wr_ready = 1;
    tick();
    wr_ready = 0;
    check("R4 idx4 not issued", wr_valid, 0);
    squash_valid = 1; squash_seq = 13;
    tick();
    squash_valid = 0;
    check("R9 second squash", free_cnt, 6);

    // R10 release on completion
    stall_set = 1; stall_idx = 3;
    tick();
    stall_set = 0;
    complete(3);
    check("R10 replay on completion", replay_go, 1);
    tick();
    check("R8 empty after retire", empty, 1);
    check("R8 free after retire", free_cnt, DEPTH - 1);

    // R5 wrap: idx 4,5,6,7,0
    for (int k = 0; k < 5; k++) begin
      int sz;
      case (k) 0: sz = 1; 1: sz = 2; 2: sz = 4; 3: sz = 8; default: sz = 1; endcase
      put(30 + k, sz, 'h200 + k, 'hB000 + k);
    end
    check("R2 free after wrap fill", free_cnt, 2);
    commit(34);
    check("R5 wrap lanes", wr_valid, 3);
    check("R5 wrap lane0 idx", lidx(0), 4);
    check("R5 wrap lane1 idx", lidx(1), 5);
    check("R5 wrap lane0 data", wr_data[DATA_W-1:0], 'hB000);
    check("R5 wrap lane1 addr", wr_addr[2*ADDR_W-1:ADDR_W], 'h201);
    wr_ready = 1;
    tick();
    check("R5 second pair lane0", lidx(0), 6);
    check("R5 second pair lane1", lidx(1), 7);
    tick();
    check("R5 wrapped single lane", wr_valid, 1);
    check("R5 wrapped idx", lidx(0), 0);
    tick();
    wr_ready = 0;
    check("R5 drained", wr_valid, 0);
    complete(0); complete(7); complete(6); complete(5);
    check("R8 reverse completion held", free_cnt, 2);
    complete(4);
    check("R8 reverse latency", free_cnt, 2);
    tick();
    check("R8 reverse all retired", empty, 1);
    check("R8 reverse free", free_cnt, DEPTH - 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule